// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block tracks the cache-line misses that have gone out to the next memory level and are still waiting for data. Each live entry is tagged with a block address. It holds the identifiers of all requests that missed on that block, in arrival order, plus a sticky flag that records whether any of them is atomic. When a second miss hits a block that is already pending, it joins the existing entry and does not allocate a new one. The table holds no line data and never talks to memory itself.

On the request side, a single address input drives two combinational answers: whether an entry for that block exists, and whether an add for that block would be refused. An add either allocates a free entry or appends to the matching one. On the fill side, a returning block marks its entry ready. The entry's index then joins a ready queue, and a registered flag reports whether the entry carries an atomic request. The drain port shows the oldest request of the oldest ready block. Each pop removes one request, and the entry is released after its last request leaves.

Top module: `mshr_merge_table`

## Requirements
- R1: After reset, `ready_o`, `probe_hit_o`, `full_o`, `fill_err_o` and `fill_atomic_o` are all low.
- R2: `probe_hit_o` is high in the same cycle exactly when a live entry carries the block address on `req_addr_i`.
- R3: For an address with no live entry, `full_o` is high exactly when all `N_ENTRIES` entries are live. An add in that state changes nothing.
- R4: For an address with a live entry, `full_o` is high exactly when that entry already holds `MAX_MERGE` requests. An add in that state is ignored, and the refused identifier never drains.
- R5: An accepted add for a pending address appends to that entry and allocates no new entry, so the number of live entries is unchanged.
- R6: A fill for a live entry that is not yet ready pushes that entry onto the ready queue. `ready_o` is high from the next cycle for as long as the queue is not empty.
- R7: The drain port presents blocks in the order their fills arrived. Within a block it presents requests in the order they were added, and each `pop_i` while `ready_o` is high advances by one request. `pop_addr_o` and `pop_id_o` are valid while `ready_o` is high.
- R8: `pop_last_o` is high when the presented request is the only one left in its entry. Popping it frees the entry, so the address no longer probes as present.
- R9: One cycle after an accepted fill, `fill_atomic_o` is high exactly when at least one request added to that entry before the fill cycle was flagged atomic.
- R10: A fill for an address with no live entry, or for an entry already marked ready, raises `fill_err_o` for one cycle, one cycle later, and changes no table or queue state.
- R11: `pop_i` while `ready_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | ADDR_W | Block address for probe, full check and add |
| probe_hit_o | output | 1 | A live entry matches `req_addr_i` |
| full_o | output | 1 | An add for `req_addr_i` would be refused |
| add_i | input | 1 | Add a request for `req_addr_i` |
| add_id_i | input | ID_W | Identifier of the added request |
| add_atomic_i | input | 1 | Added request is atomic |
| fill_i | input | 1 | Fill response arrives |
| fill_addr_i | input | ADDR_W | Block address of the fill |
| fill_err_o | output | 1 | Previous-cycle fill matched no pending entry |
| fill_atomic_o | output | 1 | Previous-cycle fill's entry holds an atomic request |
| ready_o | output | 1 | Ready queue is not empty |
| pop_i | input | 1 | Remove the presented request |
| pop_addr_o | output | ADDR_W | Block address of the presented request |
| pop_id_o | output | ID_W | Identifier of the presented request |
| pop_last_o | output | 1 | Presented request is the last in its entry |

## Verification
The bench builds the table with four entries, a merge depth of three, 6-bit addresses and 4-bit identifiers. It draws addresses from only eight values. With that setup, three adds fill a merge list and four distinct blocks fill the table, so both refusal cases, merges into ready entries, double fills and entry reuse after draining all occur many times. A reference model in the bench keeps a request list per address and a fill-order queue. Every probe, full answer, fill flag and drained identifier is compared against that model across a directed pass and a long pseudo-random mix of adds, fills and pops.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 8,
  parameter int MAX_MERGE = 4,
  localparam int CNT_W    = $clog2(MAX_MERGE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              append_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              atomic_i,
  input  logic              mark_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ID_W-1:0]   head_id_o,
  output logic              ready_o,
  output logic              atomic_o
);
  logic              valid_q, rdy_q, atom_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, base, cnt_n;
  logic [ID_W-1:0]   ids_q [MAX_MERGE];
  logic [ID_W-1:0]   ids_n [MAX_MERGE];

  // pop shifts the list down, append lands right after the surviving tail
  always_comb begin
    ids_n = ids_q;
    base  = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < MAX_MERGE - 1; i++) ids_n[i] = ids_q[i+1];
      base = cnt_q - CNT_W'(1);
    end
    if (append_i) begin
      for (int i = 0; i < MAX_MERGE; i++)
        if (CNT_W'(i) == base) ids_n[i] = id_i;
    end
    cnt_n = base + CNT_W'(append_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rdy_q   <= 1'b0;
      atom_q  <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < MAX_MERGE; i++) ids_q[i] <= '0;
    end else if (alloc_i) begin
      valid_q  <= 1'b1;
      rdy_q    <= 1'b0;
      atom_q   <= atomic_i;
      addr_q   <= addr_i;
      cnt_q    <= CNT_W'(1);
      ids_q[0] <= id_i;
    end else if (valid_q) begin
      ids_q <= ids_n;
      cnt_q <= cnt_n;
      if (cnt_n == '0) begin
        valid_q <= 1'b0;
        rdy_q   <= 1'b0;
        atom_q  <= 1'b0;
      end else begin
        if (mark_i)                rdy_q  <= 1'b1;
        if (append_i && atomic_i)  atom_q <= 1'b1;
      end
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
  assign head_id_o = ids_q[0];
  assign ready_o   = rdy_q;
  assign atomic_o  = atom_q;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_MERGE));
  a_r10_mark_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |-> (valid_q && !rdy_q));
  a_r7_pop_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (valid_q && rdy_q));
  a_r8_free_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == CNT_W'(1) && !append_i && !alloc_i) |=> !valid_q);
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = mshr_pkg::idx_w(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i [N],
  input  logic [ADDR_W-1:0] addr_i  [N],
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N-1:0] match;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      match[i] = valid_i[i] && (addr_i[i] == key_i);
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  a_r2_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/mshr_alloc.sv
module mshr_alloc #(
  parameter int N      = 8,
  localparam int IDX_W = mshr_pkg::idx_w(N),
  localparam int NC_W  = $clog2(N + 1)
) (
  input  logic             valid_i [N],
  output logic             free_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [NC_W-1:0]  used_o
);
  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    used_o     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(i);
      end
      used_o = used_o + NC_W'(valid_i[i]);
    end
  end
endmodule

// File: rtl/mshr_ready_fifo.sv
module mshr_ready_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int PW   = mshr_pkg::idx_w(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_i) begin
        mem[wr_q] <= data_i;
        wr_q      <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      end
      if (pop_i) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign cnt_o   = cnt_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table #(
  parameter int N_ENTRIES = 8,
  parameter int MAX_MERGE = 4,
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              probe_hit_o,
  output logic              full_o,
  input  logic              add_i,
  input  logic [ID_W-1:0]   add_id_i,
  input  logic              add_atomic_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              fill_err_o,
  output logic              fill_atomic_o,
  output logic              ready_o,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [ID_W-1:0]   pop_id_o,
  output logic              pop_last_o
);
  localparam int IDX_W = mshr_pkg::idx_w(N_ENTRIES);
  localparam int CNT_W = $clog2(MAX_MERGE + 1);
  localparam int NC_W  = $clog2(N_ENTRIES + 1);

  logic              e_valid [N_ENTRIES];
  logic [ADDR_W-1:0] e_addr  [N_ENTRIES];
  logic [CNT_W-1:0]  e_cnt   [N_ENTRIES];
  logic [ID_W-1:0]   e_head  [N_ENTRIES];
  logic              e_rdy   [N_ENTRIES];
  logic              e_atom  [N_ENTRIES];
  logic [N_ENTRIES-1:0] e_alloc, e_append, e_mark, e_pop;

  logic             req_hit, fill_hit, free_any;
  logic [IDX_W-1:0] req_idx, fill_idx, free_idx, q_idx;
  logic [NC_W-1:0]  used;
  logic [NC_W-1:0]  q_cnt;
  logic             q_valid, add_ok, fill_ok, pop_ok, q_pop;
  logic             fill_err_q, fill_atom_q;

  mshr_lookup #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_req_lookup (
    .clk_i, .rst_ni, .valid_i(e_valid), .addr_i(e_addr),
    .key_i(req_addr_i), .hit_o(req_hit), .idx_o(req_idx));

  mshr_lookup #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_fill_lookup (
    .clk_i, .rst_ni, .valid_i(e_valid), .addr_i(e_addr),
    .key_i(fill_addr_i), .hit_o(fill_hit), .idx_o(fill_idx));

  mshr_alloc #(.N(N_ENTRIES)) u_alloc (
    .valid_i(e_valid), .free_o(free_any), .free_idx_o(free_idx), .used_o(used));

  assign probe_hit_o = req_hit;
  assign full_o = req_hit ? (e_cnt[req_idx] == CNT_W'(MAX_MERGE)) : !free_any;
  assign add_ok  = add_i && !full_o;
  assign fill_ok = fill_i && fill_hit && !e_rdy[fill_idx];
  assign pop_ok  = pop_i && q_valid;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    assign e_alloc[i]  = add_ok && !req_hit && (free_idx == IDX_W'(i));
    assign e_append[i] = add_ok && req_hit && (req_idx == IDX_W'(i));
    assign e_mark[i]   = fill_ok && (fill_idx == IDX_W'(i));
    assign e_pop[i]    = pop_ok && (q_idx == IDX_W'(i));

    mshr_entry #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_MERGE(MAX_MERGE)) u_entry (
      .clk_i, .rst_ni,
      .alloc_i(e_alloc[i]), .append_i(e_append[i]),
      .addr_i(req_addr_i), .id_i(add_id_i), .atomic_i(add_atomic_i),
      .mark_i(e_mark[i]), .pop_i(e_pop[i]),
      .valid_o(e_valid[i]), .addr_o(e_addr[i]), .cnt_o(e_cnt[i]),
      .head_id_o(e_head[i]), .ready_o(e_rdy[i]), .atomic_o(e_atom[i]));
  end

  // queue slot retires only when the entry actually empties
  assign q_pop = pop_ok && pop_last_o && !e_append[q_idx];

  mshr_ready_fifo #(.DEPTH(N_ENTRIES), .W(IDX_W)) u_ready_q (
    .clk_i, .rst_ni, .push_i(fill_ok), .data_i(fill_idx), .pop_i(q_pop),
    .valid_o(q_valid), .data_o(q_idx), .cnt_o(q_cnt));

  assign ready_o    = q_valid;
  assign pop_addr_o = e_addr[q_idx];
  assign pop_id_o   = e_head[q_idx];
  assign pop_last_o = (e_cnt[q_idx] == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_err_q  <= 1'b0;
      fill_atom_q <= 1'b0;
    end else begin
      fill_err_q  <= fill_i && !fill_ok;
      fill_atom_q <= fill_ok && e_atom[fill_idx];
    end
  end

  assign fill_err_o    = fill_err_q;
  assign fill_atomic_o = fill_atom_q;

  a_r6_queue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= used);
  a_r7_ready_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (e_valid[q_idx] && e_rdy[q_idx]));
  a_r5_merge_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_ok && req_hit && !pop_ok) |=> (used == $past(used)));
  a_r3_refuse_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !req_hit && used == NC_W'(N_ENTRIES)) |=> (used == NC_W'(N_ENTRIES)) || $past(pop_ok));
endmodule

// File: tb/mshr_merge_table_tb.sv
`timescale 1ns/1ps
module mshr_merge_table_tb;
  localparam int NE = 4, MM = 3, AW = 6, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] req_addr = '0, fill_addr = '0, pop_addr;
  logic [IW-1:0] add_id = '0, pop_id;
  logic add = 0, add_atomic = 0, fill = 0, pop = 0;
  logic probe_hit, full, fill_err, fill_atomic, ready, pop_last;

  mshr_merge_table #(.N_ENTRIES(NE), .MAX_MERGE(MM), .ADDR_W(AW), .ID_W(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_addr_i(req_addr), .probe_hit_o(probe_hit),
    .full_o(full), .add_i(add), .add_id_i(add_id), .add_atomic_i(add_atomic),
    .fill_i(fill), .fill_addr_i(fill_addr), .fill_err_o(fill_err),
    .fill_atomic_o(fill_atomic), .ready_o(ready), .pop_i(pop),
    .pop_addr_o(pop_addr), .pop_id_o(pop_id), .pop_last_o(pop_last));

  int total = 0, bad = 0;
  int mcnt [64];
  logic [IW-1:0] mids [64][MM];
  bit mrdy [64], matom [64];
  int rq [$];
  int next_id = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nvalid();
    int n = 0;
    for (int a = 0; a < 64; a++) if (mcnt[a] > 0) n++;
    return n;
  endfunction

  task automatic idle();
    add = 0; fill = 0; pop = 0;
  endtask

  task automatic op_add(input int a, input bit at);
    bit hit, fl;
    @(negedge clk);
    idle();
    req_addr = AW'(a); add_id = IW'(next_id); add_atomic = at; add = 1;
    #1;
    hit = mcnt[a] > 0;
    fl  = hit ? (mcnt[a] == MM) : (nvalid() == NE);
    chk("R2 probe", int'(probe_hit), int'(hit));
    if (hit) chk("R4 full merge", int'(full), int'(fl));
    else     chk("R3 full new", int'(full), int'(fl));
    @(posedge clk);
    if (!fl) begin
      mids[a][mcnt[a]] = IW'(next_id);
      mcnt[a]++;
      if (at) matom[a] = 1;
    end
    next_id = (next_id + 1) % 16;
    #0.5 add = 0;
  endtask

  task automatic op_fill(input int a);
    bit er, at;
    @(negedge clk);
    idle();
    fill_addr = AW'(a); fill = 1;
    er = (mcnt[a] == 0) || mrdy[a];
    at = !er && matom[a];
    @(posedge clk);
    if (!er) begin mrdy[a] = 1; rq.push_back(a); end
    @(negedge clk);
    fill = 0;
    chk("R10 fill error", int'(fill_err), int'(er));
    chk("R9 fill atomic", int'(fill_atomic), int'(at));
    chk("R6 ready", int'(ready), int'(rq.size() > 0));
  endtask

  task automatic op_pop();
    int a;
    @(negedge clk);
    idle();
    pop = 1;
    #1;
    chk("R6 ready", int'(ready), int'(rq.size() > 0));
    if (rq.size() > 0) begin
      a = rq[0];
      chk("R7 pop addr", int'(pop_addr), a);
      chk("R7 pop id", int'(pop_id), int'(mids[a][0]));
      chk("R8 pop last", int'(pop_last), int'(mcnt[a] == 1));
    end
    @(posedge clk);
    if (rq.size() > 0) begin
      a = rq[0];
      for (int i = 0; i < MM - 1; i++) mids[a][i] = mids[a][i+1];
      mcnt[a]--;
      if (mcnt[a] == 0) begin
        mrdy[a] = 0; matom[a] = 0;
        void'(rq.pop_front());
      end
    end
    #0.5 pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 12345;
    for (int a = 0; a < 64; a++) begin mcnt[a] = 0; mrdy[a] = 0; matom[a] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", int'(ready), 0);
    chk("R1 probe", int'(probe_hit), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 fill_err", int'(fill_err), 0);
    chk("R1 fill_atomic", int'(fill_atomic), 0);
    rst_n = 1;

    // R4/R5: merge up to depth, then refuse
    op_add(5, 0); op_add(5, 1); op_add(5, 0); op_add(5, 1);
    // R3: fill the table, then refuse a new block
    op_add(6, 0); op_add(7, 0); op_add(8, 0); op_add(9, 0);
    op_pop();                       // R11: nothing ready
    op_fill(9);                     // R10: no entry
    op_fill(6);
    op_fill(5);                     // R9: atomic present
    op_fill(5);                     // R10: already ready
    op_add(6, 1);                   // merge into ready entry
    repeat (6) op_pop();            // R7 order, R8 last and free
    op_add(6, 0);                   // R8: freed address reallocates
    op_pop();                       // R11
    op_fill(7); op_fill(8); op_fill(6);
    repeat (4) op_pop();

    for (int n = 0; n < 3000; n++) begin
      int r, a;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 16) & 32'h7fff;
      a = r % 8;
      case ((r / 8) % 3)
        0: op_add(a, ((r / 32) % 4) == 0);
        1: op_fill(a);
        default: op_pop();
      endcase
    end
    while (rq.size() > 0) op_pop();
    op_pop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule